// File: doc/BRIEF.md
# Core Event Controller Register Block

This block is the event and interrupt controller that sits beside a small processor core. It has a table of sixteen 32-bit handler addresses, one per priority level, and four control registers: a 9-bit override register, a 16-bit mask, a read-only latch of raised events and a read-only set of levels now in service. Requests come from software, as a raise command naming a level, or from hardware, as a bit of the external event input. Each request sets its bit in the latch. A latched level whose mask bit is set becomes a candidate. The most urgent candidate is taken when it outranks every level already in service.

Taking a level clears its latch bit and sets its bit in the in-service register. The block then presents that level's handler address together with a one-clock take strobe. A return strobe from the core retires the most urgent level in service, and the next candidate can then be taken. A global disable command saves the mask to an output register and clears it. A global enable command loads a supplied value into the mask. The lowest mask bits are hard-wired to one, so the most urgent levels can never be masked.

Register access is one word-addressed port: a byte offset, a write strobe and write data. Read data is combinational from the offset.

Top module: `ecr_event_ctrl`

## Requirements
- R1: Vector entry n is written and read at byte offset 4·n for n in 0..15. Entry 0 has no storage and always reads 0.
- R2: The override register at offset 0x100 keeps only the low 9 bits of a write. Writing 0x1FF reads 0x1FF, and writing 0xFFFFFFFF also reads 0x1FF.
- R3: The mask register at offset 0x104 is 16 bits wide. Its bits 4..0 always read 1: writing 0 reads 0x001F, and writing 0x0FFF reads 0x0FFF. A level in 0..4 is taken even while the mask is otherwise clear.
- R4: Bus writes to the in-service register (offset 0x108) and to the latch register (offset 0x10C) have no effect. Both still read 0 after 0xFFFF is written to them.
- R5: A raise command for level n sets latch bit n at the next clock edge, and so does a high external event input bit n. Both are visible at offset 0x10C.
- R6: A latched level whose mask bit is clear stays latched and is not taken. With the mask at 0x0FFF, raising levels 12 and 13 leaves the latch reading 0x3000, the in-service register reading 0, and no take.
- R7: When a level is taken at a clock edge, take is high for the next cycle. During that cycle take_lvl holds the level and take_vec holds its vector entry. At the same edge the latch bit clears and the in-service bit sets.
- R8: Among candidates latched at the same time, the lowest level number is taken first.
- R9: A candidate is taken only if its level number is below every bit set in the in-service register. A more urgent level therefore nests above one in service. A return strobe clears the lowest-numbered set in-service bit, and a blocked candidate can then be taken.
- R10: Global disable copies the mask to saved_mask and leaves only the hard-wired bits set in the mask. Global enable loads glb_en_val into the mask, with the hard-wired bits still forced to 1. Enabling with 0xFFFF reads back 0xFFFF.
- R11: Synchronous active-low reset clears the vector table, override, latch and in-service registers and the take strobe. It sets the mask to 0x001F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_in | input | 16 | External event requests, one bit per level |
| raise_en | input | 1 | Software raise command |
| raise_lvl | input | 4 | Level named by the raise command |
| glb_dis | input | 1 | Global disable command |
| glb_en | input | 1 | Global enable command |
| glb_en_val | input | 16 | Mask value loaded by global enable |
| saved_mask | output | 16 | Mask saved by the last global disable |
| take | output | 1 | One-cycle strobe: a level was taken |
| take_lvl | output | 4 | Level taken |
| take_vec | output | 32 | Vector entry of the level taken |
| ret | input | 1 | Return strobe: retire the most urgent level in service |

## Verification
The hardest case to reach is a nested state: a level in service, a more urgent level preempting it, and less urgent candidates waiting behind both. Only the return strobe should release them, and only in priority order. The stimulus drives several external event bits in a single cycle so that candidates become latched together. It also raises a low-urgency level first and then pulses a more urgent external bit, so that nesting happens. The in-service and latch registers are read between return strobes. It also holds an event in the latch under a cleared mask after a global disable. A global enable with a chosen value then releases that one event.

// File: rtl/ecr_pkg.sv
// Package: shared constants of the event controller register block.
// Assumes byte-addressed word registers and a vector table that fits below
// the control register window at offset 0x100.
package ecr_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int NUM_LVL  = 16;
    localparam int VEC_W    = 32;
    localparam int OVR_W    = 9;
    localparam int FIXED_LO = 5;

    localparam logic [ADDR_W-1:0] OFS_OVR  = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_MASK = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_PEND = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_LAT  = 12'h10C;
endpackage

// File: rtl/ecr_prio_pick.sv
// Module: lowest-index picker. Reports whether any request bit is set and the
// index of the lowest set bit. Assumes index 0 is the most urgent.
module ecr_prio_pick #(
    parameter int N  = 16,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [LW-1:0] idx
);
    // Scan from the top so that the lowest set bit is the last one kept.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = LW'(i);
        end
    end
endmodule

// File: rtl/ecr_vec_table.sv
// Module: handler vector table. Entry 0 has no storage and reads zero. The
// other entries are flops with one write port, one bus read port and one
// read port for the arbiter. Assumes write index and data are valid with wr_en.
module ecr_vec_table #(
    parameter int N  = 16,
    parameter int W  = 32,
    parameter int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [LW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    input  logic [LW-1:0] tk_idx,
    output logic [W-1:0]  tk_data
);
    logic [N-1:0][W-1:0] ent;

    for (genvar g = 0; g < N; g++) begin : g_ent
        if (g == 0) begin : g_fixed
            assign ent[g] = '0;
        end else begin : g_store
            logic [W-1:0] q;
            // Hold one vector; cleared by reset, loaded on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else if (wr_en && (wr_idx == LW'(g))) q <= wr_data;
            end
            assign ent[g] = q;
        end
    end

    assign rd_data = ent[rd_idx];
    assign tk_data = ent[tk_idx];
endmodule

// File: rtl/ecr_evt_state.sv
// Module: event state. Holds the latch, in-service, mask and saved-mask
// registers. Assumes take_go is asserted only when take_idx is a legal
// candidate. Enable wins over disable, and disable wins over a bus mask write.
module ecr_evt_state #(
    parameter int N        = 16,
    parameter int LW       = $clog2(N),
    parameter int FIXED_LO = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  set_bits,
    input  logic          take_go,
    input  logic [LW-1:0] take_idx,
    input  logic          ret,
    input  logic          glb_dis,
    input  logic          glb_en,
    input  logic [N-1:0]  glb_en_val,
    input  logic          mask_we,
    input  logic [N-1:0]  mask_wdata,
    output logic [N-1:0]  latch_q,
    output logic [N-1:0]  pend_q,
    output logic [N-1:0]  mask_q,
    output logic [N-1:0]  saved_q
);
    localparam logic [N-1:0] FIXED = N'((64'(1) << FIXED_LO) - 64'(1));

    logic [N-1:0] take_bit, ret_bit, latch_n, pend_n, mask_n;

    // Next-state terms for latch, in-service set and mask.
    always_comb begin
        take_bit = take_go ? (N'(1) << take_idx) : '0;
        ret_bit  = ret ? (pend_q & (~pend_q + N'(1))) : '0;
        latch_n  = (latch_q & ~take_bit) | set_bits;
        pend_n   = (pend_q & ~ret_bit) | take_bit;
        if (glb_en)       mask_n = glb_en_val;
        else if (glb_dis) mask_n = '0;
        else if (mask_we) mask_n = mask_wdata;
        else              mask_n = mask_q;
        mask_n = mask_n | FIXED;
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            pend_q  <= '0;
            mask_q  <= FIXED;
            saved_q <= '0;
        end else begin
            latch_q <= latch_n;
            pend_q  <= pend_n;
            mask_q  <= mask_n;
            if (glb_dis) saved_q <= mask_q;
        end
    end
endmodule

// File: rtl/ecr_event_ctrl.sv
// Module: top of the event controller register block. Decodes the register
// port and arbitrates latched, unmasked events against the in-service set.
// It registers the take strobe, level and vector. Assumes word-aligned offsets.
module ecr_event_ctrl
    import ecr_pkg::*;
#(
    parameter int NUM_LVL  = ecr_pkg::NUM_LVL,
    parameter int VEC_W    = ecr_pkg::VEC_W,
    parameter int OVR_W    = ecr_pkg::OVR_W,
    parameter int FIXED_LO = ecr_pkg::FIXED_LO,
    localparam int LW      = $clog2(NUM_LVL)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_LVL-1:0]  evt_in,
    input  logic                raise_en,
    input  logic [LW-1:0]       raise_lvl,
    input  logic                glb_dis,
    input  logic                glb_en,
    input  logic [NUM_LVL-1:0]  glb_en_val,
    output logic [NUM_LVL-1:0]  saved_mask,
    output logic                take,
    output logic [LW-1:0]       take_lvl,
    output logic [VEC_W-1:0]    take_vec,
    input  logic                ret
);
    logic               vec_hit, vec_we, mask_we;
    logic [LW-1:0]      vec_idx;
    logic [VEC_W-1:0]   vec_rd, vec_tk;
    logic [NUM_LVL-1:0] set_bits, latch_q, pend_q, mask_q, cand;
    logic               cand_any, pend_any, take_go;
    logic [LW-1:0]      cand_idx, pend_idx;
    logic [OVR_W-1:0]   ovr_q;

    // Address decode for the vector window and the writable registers.
    always_comb begin
        vec_hit = (bus_addr[ADDR_W-1:LW+2] == '0) && (bus_addr[1:0] == 2'b00);
        vec_idx = bus_addr[LW+1:2];
        vec_we  = bus_we && vec_hit;
        mask_we = bus_we && (bus_addr == OFS_MASK);
    end

    // Request sources: external inputs plus the decoded raise command.
    always_comb begin
        set_bits = evt_in;
        if (raise_en) set_bits = set_bits | (NUM_LVL'(1) << raise_lvl);
    end

    ecr_vec_table #(.N(NUM_LVL), .W(VEC_W), .LW(LW)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (vec_we),
        .wr_idx  (vec_idx),
        .wr_data (bus_wdata[VEC_W-1:0]),
        .rd_idx  (vec_idx),
        .rd_data (vec_rd),
        .tk_idx  (cand_idx),
        .tk_data (vec_tk)
    );

    ecr_evt_state #(.N(NUM_LVL), .LW(LW), .FIXED_LO(FIXED_LO)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_bits   (set_bits),
        .take_go    (take_go),
        .take_idx   (cand_idx),
        .ret        (ret),
        .glb_dis    (glb_dis),
        .glb_en     (glb_en),
        .glb_en_val (glb_en_val),
        .mask_we    (mask_we),
        .mask_wdata (bus_wdata[NUM_LVL-1:0]),
        .latch_q    (latch_q),
        .pend_q     (pend_q),
        .mask_q     (mask_q),
        .saved_q    (saved_mask)
    );

    assign cand = latch_q & mask_q;

    ecr_prio_pick #(.N(NUM_LVL), .LW(LW)) u_pick_cand (
        .req (cand),
        .any (cand_any),
        .idx (cand_idx)
    );

    ecr_prio_pick #(.N(NUM_LVL), .LW(LW)) u_pick_pend (
        .req (pend_q),
        .any (pend_any),
        .idx (pend_idx)
    );

    // Take decision: a candidate must outrank every level in service.
    assign take_go = cand_any && (!pend_any || (cand_idx < pend_idx));

    // Registered take strobe with its level and vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take     <= 1'b0;
            take_lvl <= '0;
            take_vec <= '0;
        end else begin
            take <= take_go;
            if (take_go) begin
                take_lvl <= cand_idx;
                take_vec <= vec_tk;
            end
        end
    end

    // Override register: keeps only its defined width.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= '0;
        else if (bus_we && (bus_addr == OFS_OVR)) ovr_q <= bus_wdata[OVR_W-1:0];
    end

    // Read mux over the vector window and the control registers.
    always_comb begin
        bus_rdata = '0;
        if (vec_hit)                    bus_rdata = DATA_W'(vec_rd);
        else if (bus_addr == OFS_OVR)   bus_rdata = DATA_W'(ovr_q);
        else if (bus_addr == OFS_MASK)  bus_rdata = DATA_W'(mask_q);
        else if (bus_addr == OFS_PEND)  bus_rdata = DATA_W'(pend_q);
        else if (bus_addr == OFS_LAT)   bus_rdata = DATA_W'(latch_q);
    end
endmodule

// File: rtl/ecr_event_ctrl_chk.sv
// Module: assertion checker for ecr_event_ctrl, attached with bind.
// Assumes it sees the top's in-service and mask registers through the bind.
module ecr_event_ctrl_chk #(
    parameter int N        = 16,
    parameter int LW       = 4,
    parameter int FIXED_LO = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [11:0]       bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              take,
    input logic [LW-1:0]     take_lvl,
    input logic [N-1:0]      pend_q,
    input logic [N-1:0]      mask_q,
    input logic [N-1:0]      saved_mask,
    input logic              glb_dis,
    input logic              glb_en,
    input logic              ret
);
    localparam logic [N-1:0] FIXED = N'((64'(1) << FIXED_LO) - 64'(1));

    AST_ENTRY0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 12'h000) |-> (bus_rdata == 32'h0)); // R1
    AST_MASK_LOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 12'h104) |-> (bus_rdata[FIXED_LO-1:0] == FIXED[FIXED_LO-1:0])); // R3
    AST_TAKE_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend_q[take_lvl]); // R7
    AST_TAKE_MOST_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((pend_q & ((N'(1) << take_lvl) - N'(1))) == '0)); // R9
    AST_PEND_ONLY_TAKE_RET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pend_q) |-> (take || $past(ret))); // R4
    AST_DISABLE_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
        glb_dis |=> (saved_mask == $past(mask_q))); // R10
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_dis && !glb_en) |=> (mask_q == FIXED)); // R10
endmodule

bind ecr_event_ctrl ecr_event_ctrl_chk #(.N(NUM_LVL), .LW(LW), .FIXED_LO(FIXED_LO)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .take       (take),
    .take_lvl   (take_lvl),
    .pend_q     (pend_q),
    .mask_q     (mask_q),
    .saved_mask (saved_mask),
    .glb_dis    (glb_dis),
    .glb_en     (glb_en),
    .ret        (ret)
);

// File: tb/test_ecr_event_ctrl.sv
// Scoreboard bench: driver tasks queue expected reads and takes, and a
// monitor compares them at the falling edge.
module test_ecr_event_ctrl;
    localparam time CLK_P = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] evt_in = '0;
    logic        raise_en = 1'b0;
    logic [3:0]  raise_lvl = '0;
    logic        glb_dis = 1'b0;
    logic        glb_en = 1'b0;
    logic [15:0] glb_en_val = '0;
    logic [15:0] saved_mask;
    logic        take;
    logic [3:0]  take_lvl;
    logic [31:0] take_vec;
    logic        ret = 1'b0;
    logic        rd_probe = 1'b0;

    int tests = 0;
    int fails = 0;

    typedef struct { logic [31:0] exp; string tag; } rd_item_t;
    typedef struct { logic [3:0] lvl; logic [31:0] vec; string tag; } tk_item_t;
    rd_item_t rd_q[$];
    tk_item_t tk_q[$];
    rd_item_t rd_it;
    tk_item_t tk_it;

    always #(CLK_P/2) clk = ~clk;

    ecr_event_ctrl i_ecr_event_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .raise_en(raise_en), .raise_lvl(raise_lvl), .glb_dis(glb_dis),
        .glb_en(glb_en), .glb_en_val(glb_en_val), .saved_mask(saved_mask),
        .take(take), .take_lvl(take_lvl), .take_vec(take_vec), .ret(ret)
    );

    function automatic logic [31:0] vecval(int n);
        return (n == 0) ? 32'h0 : (32'h1111_0000 * n + 32'h0000_5A00 + n);
    endfunction

    function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    // Monitor: pops expected items as reads and takes occur.
    always @(negedge clk) begin
        if (rst_n && rd_probe) begin
            if (rd_q.size() == 0) chk("read with empty queue", 32'h1, 32'h0);
            else begin
                rd_it = rd_q.pop_front();
                chk(rd_it.tag, bus_rdata, rd_it.exp);
            end
        end
        if (rst_n && take) begin
            if (tk_q.size() == 0) chk("R6 unexpected take", {28'h0, take_lvl}, 32'hFFFF_FFFF);
            else begin
                tk_it = tk_q.pop_front();
                chk({tk_it.tag, " level"}, {28'h0, take_lvl}, {28'h0, tk_it.lvl});
                chk({tk_it.tag, " vector"}, take_vec, tk_it.vec);
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
        rd_q.push_back('{exp: e, tag: tag});
        bus_addr = a; rd_probe = 1'b1;
        step();
        rd_probe = 1'b0;
    endtask

    task automatic expect_take(int lvl, string tag);
        tk_q.push_back('{lvl: 4'(lvl), vec: vecval(lvl), tag: tag});
    endtask

    task automatic raise(int lvl);
        raise_en = 1'b1; raise_lvl = 4'(lvl);
        step();
        raise_en = 1'b0;
    endtask

    task automatic pulse_evt(logic [15:0] bits);
        evt_in = bits;
        step();
        evt_in = '0;
    endtask

    task automatic do_ret();
        ret = 1'b1;
        step();
        ret = 1'b0;
    endtask

    task automatic takes_done(string tag);
        chk({tag, " outstanding takes"}, rd_q.size() + tk_q.size(), 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        // R11 reset state
        rd(12'h014, 32'h0, "R11 vector 5 after reset");
        rd(12'h100, 32'h0, "R11 override after reset");
        rd(12'h104, 32'h001F, "R11 mask after reset");
        rd(12'h108, 32'h0, "R11 in-service after reset");
        rd(12'h10C, 32'h0, "R11 latch after reset");
        // R1 vector table
        wr(12'h000, 32'hDEAD_BEEF);
        for (int n = 1; n < 16; n++) wr(12'(4 * n), vecval(n));
        for (int n = 0; n < 16; n++) rd(12'(4 * n), vecval(n), "R1 vector readback");
        // R2 override width
        wr(12'h100, 32'h1FF);
        rd(12'h100, 32'h1FF, "R2 override 0x1FF");
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100, 32'h1FF, "R2 override upper bits dropped");
        // R3 mask hard-wired low bits
        wr(12'h104, 32'h0);
        rd(12'h104, 32'h001F, "R3 mask write zero");
        wr(12'h104, 32'h0FFF);
        rd(12'h104, 32'h0FFF, "R3 mask write 0x0FFF");
        // R4 read-only registers ignore writes
        wr(12'h108, 32'hFFFF);
        wr(12'h10C, 32'hFFFF);
        rd(12'h108, 32'h0, "R4 in-service ignores write");
        rd(12'h10C, 32'h0, "R4 latch ignores write");
        // R5 R6 masked raises stay latched
        raise(12);
        raise(13);
        step(4);
        rd(12'h10C, 32'h3000, "R6 latch holds masked levels");
        rd(12'h108, 32'h0, "R6 nothing in service");
        takes_done("R6");
        // R10 R8 enable all, 12 taken before 13
        expect_take(12, "R8 first of 12 and 13");
        glb_en_val = 16'hFFFF; glb_en = 1'b1;
        step();
        glb_en = 1'b0;
        step(3);
        rd(12'h104, 32'hFFFF, "R10 enable all ones");
        rd(12'h108, 32'h1000, "R7 in-service after take");
        rd(12'h10C, 32'h2000, "R9 level 13 blocked");
        takes_done("R9 blocked");
        expect_take(13, "R9 after return");
        do_ret();
        step(3);
        rd(12'h108, 32'h2000, "R9 in-service after return");
        rd(12'h10C, 32'h0, "R7 latch cleared");
        do_ret();
        step(2);
        takes_done("R9");
        // R9 nesting: 15 in service, external 3 preempts
        expect_take(15, "R5 raise 15");
        raise(15);
        step(3);
        rd(12'h108, 32'h8000, "R9 level 15 in service");
        expect_take(3, "R5 external level 3 nests");
        pulse_evt(16'h0008);
        step(3);
        rd(12'h108, 32'h8008, "R9 nested in-service");
        do_ret();
        step(2);
        rd(12'h108, 32'h8000, "R9 return retires level 3");
        do_ret();
        step(2);
        rd(12'h108, 32'h0, "R9 return retires level 15");
        takes_done("R9 nest");
        // R8 simultaneous external events 6, 9, 11
        expect_take(6, "R8 simultaneous first");
        expect_take(9, "R8 simultaneous second");
        expect_take(11, "R8 simultaneous third");
        pulse_evt(16'h0A40);
        step(3);
        rd(12'h108, 32'h0040, "R8 level 6 in service");
        rd(12'h10C, 32'h0A00, "R8 levels 9 and 11 waiting");
        do_ret();
        step(3);
        rd(12'h108, 32'h0200, "R8 level 9 in service");
        do_ret();
        step(3);
        do_ret();
        step(3);
        rd(12'h108, 32'h0, "R8 all retired");
        takes_done("R8");
        // R10 disable saves and clears the mask
        glb_dis = 1'b1;
        step();
        glb_dis = 1'b0;
        chk("R10 saved mask", {16'h0, saved_mask}, 32'hFFFF);
        rd(12'h104, 32'h001F, "R10 mask after disable");
        expect_take(2, "R3 hard-wired level 2 under disable");
        raise(2);
        step(3);
        do_ret();
        step(2);
        raise(10);
        step(4);
        rd(12'h10C, 32'h0400, "R10 level 10 held while disabled");
        takes_done("R10 disabled");
        expect_take(10, "R10 enable releases level 10");
        glb_en_val = 16'h0400; glb_en = 1'b1;
        step();
        glb_en = 1'b0;
        step(3);
        rd(12'h104, 32'h041F, "R10 enable value with fixed bits");
        rd(12'h108, 32'h0400, "R10 level 10 in service");
        do_ret();
        step(2);
        takes_done("R10");
        // R11 reset in mid-run
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step();
        rd(12'h01C, 32'h0, "R11 vector 7 cleared");
        rd(12'h100, 32'h0, "R11 override cleared");
        rd(12'h104, 32'h001F, "R11 mask reset value");
        rd(12'h108, 32'h0, "R11 in-service cleared");
        step(2);
        takes_done("R11");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule